// File: doc/BRIEF.md
# Interrupt Status Controller with Level and Message Outputs

This block keeps a 32-bit sticky interrupt-status word for a device function. Bits get set in two ways. Software can write a raise register. Internal units can also pulse a request line. Here source 0 is the compute unit and source 1 is the DMA engine. Software clears bits by writing a lower register, and it reads the word back at a status offset.

The block drives one of two outputs, chosen by a mode input. In level mode a registered interrupt line follows the raise and lower events. In message mode each raise event produces a single-cycle pulse for a message-signalled interrupt sender. Lowering bits in message mode only changes the stored word. Reads are combinational from the register. Writes and source requests take effect at the next rising clock edge, and both outputs are registered so they line up with the updated word.

Top module: `irq_status_ctrl`

## Requirements
- R1: After synchronous reset the status word is 0, and both `irq_line` and `msg_pulse` are low.
- R2: When `rd_addr` is 0x24, `rd_data` shows the current status word.
- R3: A write to offset 0x60 ORs `wr_data` into the status word at the next edge.
- R4: A write to offset 0x64 clears, at the next edge, every status bit that is 1 in `wr_data`.
- R5: A request on `src_raise[0]` sets status bit 0 and a request on `src_raise[1]` sets status bit 8 (bit position = source index × 8).
- R6: In one cycle, all source requests and a software write are merged: the new word is (old | raise bits) & ~lower bits.
- R7: In level mode (`msg_mode`=0) the line goes high after a raise event whose resulting word is non-zero. It goes low only after a lower write whose resulting word is zero. A lower that leaves bits set keeps it high.
- R8: In message mode (`msg_mode`=1) every raise event whose resulting word is non-zero gives exactly one `msg_pulse` cycle, even if the bits were already set. The line keeps its value.
- R9: In message mode a lower write with no raise in the same cycle changes only the word: no pulse, no line change.
- R10: In level mode `msg_pulse` never rises.
- R11: Writes to any offset other than 0x60 and 0x64 leave the word unchanged. Reads from any offset other than 0x24 return 0xFFFFFFFF.
- R12: A raise event that leaves the word zero (raise write of 0 with an empty word) changes neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_mode | input | 1 | 0 = level line output, 1 = message pulse output |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| src_raise | input | 2 | Internal raise requests; index 0 compute, 1 DMA |
| irq_line | output | 1 | Level interrupt line |
| msg_pulse | output | 1 | One-cycle message interrupt request |

## Verification
The overlap of interest is an internal source request landing in the same cycle as a software lower write. That cycle changes the word twice, and it also decides both the line and the pulse. Directed steps drive a DMA request together with a lower write whose mask covers that same bit and then one that leaves other bits set. Random steps then mix source requests with raise, lower and stray writes in both modes. A bench model computes the merged word, the line and the pulse for each edge, and each one is compared after that edge.

// File: rtl/irq_stat_pkg.sv
`timescale 1ns/1ps
package irq_stat_pkg;

    localparam int unsigned OFS_STATUS = 32'h24;
    localparam int unsigned OFS_RAISE  = 32'h60;
    localparam int unsigned OFS_LOWER  = 32'h64;

    typedef enum logic {
        MODE_LEVEL = 1'b0,
        MODE_MSG   = 1'b1
    } irq_mode_e;

    typedef struct packed {
        logic raise_ev;
        logic lower_ev;
    } irq_evt_t;

    function automatic int unsigned src_bit_pos(input int unsigned idx,
                                                input int unsigned stride);
        return idx * stride;
    endfunction

endpackage

// File: rtl/irq_req_decode.sv
`timescale 1ns/1ps
module irq_req_decode
    import irq_stat_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_SRC    = 2,
    parameter int unsigned SRC_STRIDE = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NUM_SRC-1:0] src_raise,
    output logic [DATA_W-1:0] set_mask,
    output logic [DATA_W-1:0] clr_mask,
    output irq_evt_t          evt
);
    logic [DATA_W-1:0] src_mask;
    logic              sw_raise;
    logic              sw_lower;

    always_comb begin
        src_mask = '0;
        for (int unsigned i = 0; i < NUM_SRC; i++) begin
            src_mask[src_bit_pos(i, SRC_STRIDE)] = src_raise[i];
        end
    end

    assign sw_raise = wr_en && (wr_addr == ADDR_W'(OFS_RAISE));
    assign sw_lower = wr_en && (wr_addr == ADDR_W'(OFS_LOWER));

    assign set_mask     = src_mask | (sw_raise ? wr_data : '0);
    assign clr_mask     = sw_lower ? wr_data : '0;
    assign evt.raise_ev = sw_raise || (|src_raise);
    assign evt.lower_ev = sw_lower;
endmodule

// File: rtl/irq_status_reg.sv
`timescale 1ns/1ps
module irq_status_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] status_q,
    output logic              nxt_nonzero
);
    logic [DATA_W-1:0] status_d;

    // raise bits first, then the clear mask wins
    assign status_d    = (status_q | set_mask) & ~clr_mask;
    assign nxt_nonzero = |status_d;

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end
endmodule

// File: rtl/irq_out_gen.sv
`timescale 1ns/1ps
module irq_out_gen
    import irq_stat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_mode_e mode,
    input  irq_evt_t  evt,
    input  logic      nxt_nonzero,
    output logic      irq_line,
    output logic      msg_pulse
);
    logic line_d;
    logic pulse_d;

    always_comb begin
        line_d  = irq_line;
        pulse_d = 1'b0;
        unique case (mode)
            MODE_LEVEL: begin
                if (evt.raise_ev && nxt_nonzero)       line_d = 1'b1;
                else if (evt.lower_ev && !nxt_nonzero) line_d = 1'b0;
            end
            MODE_MSG: begin
                pulse_d = evt.raise_ev && nxt_nonzero;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_line  <= 1'b0;
            msg_pulse <= 1'b0;
        end else begin
            irq_line  <= line_d;
            msg_pulse <= pulse_d;
        end
    end
endmodule

// File: rtl/irq_status_ctrl.sv
`timescale 1ns/1ps
module irq_status_ctrl
    import irq_stat_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_SRC    = 2,
    parameter int unsigned SRC_STRIDE = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               msg_mode,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] src_raise,
    output logic               irq_line,
    output logic               msg_pulse
);
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] clr_mask;
    logic [DATA_W-1:0] status_q;
    logic              nxt_nonzero;
    irq_evt_t          evt;
    irq_mode_e         mode;

    assign mode = irq_mode_e'(msg_mode);

    irq_req_decode #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .NUM_SRC(NUM_SRC), .SRC_STRIDE(SRC_STRIDE)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .src_raise(src_raise), .set_mask(set_mask),
        .clr_mask(clr_mask), .evt(evt)
    );

    irq_status_reg #(.DATA_W(DATA_W)) u_reg (
        .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask),
        .status_q(status_q), .nxt_nonzero(nxt_nonzero)
    );

    irq_out_gen u_out (
        .clk(clk), .rst(rst), .mode(mode), .evt(evt),
        .nxt_nonzero(nxt_nonzero), .irq_line(irq_line), .msg_pulse(msg_pulse)
    );

    assign rd_data = (rd_addr == ADDR_W'(OFS_STATUS)) ? status_q : '1;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
`timescale 1ns/1ps
module irq_status_ctrl_chk
    import irq_stat_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_SRC = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               msg_mode,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic [NUM_SRC-1:0] src_raise,
    input logic [DATA_W-1:0]  status,
    input logic               irq_line,
    input logic               msg_pulse
);
    logic is_raise, is_lower;
    assign is_raise = wr_en && (wr_addr == ADDR_W'(OFS_RAISE));
    assign is_lower = wr_en && (wr_addr == ADDR_W'(OFS_LOWER));

    a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status == '0 && !irq_line && !msg_pulse));

    a_r3_raise_sets: assert property (@(posedge clk) disable iff (rst)
        is_raise |=> ((status & $past(wr_data)) == $past(wr_data)));

    a_r4_lower_clears: assert property (@(posedge clk) disable iff (rst)
        is_lower |=> ((status & $past(wr_data)) == '0));

    a_r5_src0_bit: assert property (@(posedge clk) disable iff (rst)
        (src_raise[0] && !is_lower) |=> status[0]);

    a_r7_level_high: assert property (@(posedge clk) disable iff (rst)
        (!msg_mode && is_raise && ((status | wr_data) != '0)) |=> irq_line);

    a_r8_msg_line_hold: assert property (@(posedge clk) disable iff (rst)
        msg_mode |=> $stable(irq_line));

    a_r9_msg_lower_quiet: assert property (@(posedge clk) disable iff (rst)
        (msg_mode && is_lower && src_raise == '0) |=> !msg_pulse);

    a_r10_level_no_pulse: assert property (@(posedge clk) disable iff (rst)
        !msg_mode |=> !msg_pulse);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)
) u_chk (
    .clk(clk), .rst(rst), .msg_mode(msg_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .src_raise(src_raise),
    .status(status_q), .irq_line(irq_line), .msg_pulse(msg_pulse)
);

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msg_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h24;
    logic [31:0] rd_data;
    logic [1:0]  src_raise = '0;
    logic        irq_line;
    logic        msg_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_stat = '0;
    logic        m_line = 1'b0;
    logic        m_pulse = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_ctrl u_dut (
        .clk(clk), .rst(rst), .msg_mode(msg_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .src_raise(src_raise),
        .irq_line(irq_line), .msg_pulse(msg_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt_stat(input logic [31:0] s, input logic we,
        input logic [7:0] wa, input logic [31:0] wd, input logic [1:0] sr);
        logic [31:0] set, clr;
        set = {23'b0, sr[1], 7'b0, sr[0]};
        if (we && wa == 8'h60) set |= wd;
        clr = (we && wa == 8'h64) ? wd : 32'h0;
        return (s | set) & ~clr;
    endfunction

    task automatic step(input logic we, input logic [7:0] wa, input logic [31:0] wd,
                        input logic [1:0] sr, input logic mm, input logic [7:0] ra,
                        input string tag);
        logic [31:0] n;
        logic rev, lev;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; src_raise = sr;
        msg_mode = mm; rd_addr = ra;
        @(posedge clk);
        n   = nxt_stat(m_stat, we, wa, wd, sr);
        rev = (we && wa == 8'h60) || (sr != 2'b00);
        lev = we && wa == 8'h64;
        m_pulse = mm && rev && (n != 0);
        if (!mm) begin
            if (rev && n != 0)       m_line = 1'b1;
            else if (lev && n == 0)  m_line = 1'b0;
        end
        m_stat = n;
        #1;
        check({tag, " status"}, rd_data, (ra == 8'h24) ? m_stat : 32'hFFFF_FFFF);
        check({tag, " line"},   {31'b0, irq_line},  {31'b0, m_line});
        check({tag, " pulse"},  {31'b0, msg_pulse}, {31'b0, m_pulse});
        wr_en = 1'b0; src_raise = '0; rd_addr = 8'h24;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1 status", rd_data, 32'h0);
        check("R1 line", {31'b0, irq_line}, 32'h0);
        check("R1 pulse", {31'b0, msg_pulse}, 32'h0);

        // level mode
        step(1, 8'h60, 32'h0, 2'b00, 0, 8'h24, "R12 zero raise");
        step(1, 8'h60, 32'h0000_0005, 2'b00, 0, 8'h24, "R3 R7 raise");
        step(0, 8'h00, 32'h0, 2'b00, 0, 8'h24, "R2 read");
        step(1, 8'h64, 32'h0000_0001, 2'b00, 0, 8'h24, "R7 partial lower");
        step(1, 8'h64, 32'h0000_0004, 2'b00, 0, 8'h24, "R4 R7 full lower");
        step(0, 8'h00, 32'h0, 2'b01, 0, 8'h24, "R5 src0");
        step(0, 8'h00, 32'h0, 2'b10, 0, 8'h24, "R5 src1");
        step(1, 8'h64, 32'h0000_0101, 2'b10, 0, 8'h24, "R6 merge clear wins");
        step(1, 8'h64, 32'h0000_0001, 2'b11, 0, 8'h24, "R6 merge keep dma");
        step(1, 8'h24, 32'hFFFF_FFFF, 2'b00, 0, 8'h24, "R11 write status ignored");
        step(1, 8'h30, 32'h00F0_0000, 2'b00, 0, 8'h00, "R11 stray write unmapped read");
        step(1, 8'h64, 32'hFFFF_FFFF, 2'b00, 0, 8'h24, "R4 clear all");
        // message mode
        step(1, 8'h60, 32'h8000_0000, 2'b00, 1, 8'h24, "R8 first raise");
        step(1, 8'h60, 32'h8000_0000, 2'b00, 1, 8'h24, "R8 repeat raise");
        step(0, 8'h00, 32'h0, 2'b01, 1, 8'h24, "R8 src raise");
        step(1, 8'h64, 32'hFFFF_FFFF, 2'b00, 1, 8'h24, "R9 lower quiet");
        step(1, 8'h60, 32'h0, 2'b00, 1, 8'h24, "R12 zero raise msg");
        step(0, 8'h00, 32'h0, 2'b00, 0, 8'h24, "R10 idle level");

        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            case ($urandom_range(0, 4))
                0, 1: a = 8'h60;
                2, 3: a = 8'h64;
                default: a = 8'h30;
            endcase
            d = $urandom & $urandom & $urandom;
            step($urandom_range(0, 3) != 0, a, d, 2'($urandom_range(0, 3) == 0 ? $urandom : 0),
                 (i / 500) % 2 == 1, ($urandom_range(0, 9) == 0) ? 8'h28 : 8'h24,
                 "R6 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule